// File: doc/BRIEF.md
# Programmable UART Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. Bytes enter through a write port into a 16-entry queue. A frame engine takes them from the queue one at a time and sends each one as a frame. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period. Software sets the character length, parity mode and stop length on a configuration port. The engine samples these settings at the moment it takes a byte from the queue, so a change made during a frame applies from the next frame.

A baud divider produces one pulse every `divisor` clocks. This pulse is the oversampling tick, and every start, data and parity bit lasts sixteen ticks. Three controls can hold back transmission. A break control forces the line low and blocks new frames. A flow-control enable makes each frame start depend on the clear-to-send input. An interrupt output reports when the queue has run dry.

Top module: `uart_tx_core`

## Requirements
- R1: Reset behaviour. While reset is asserted and after it is released, `txd` is high, the queue is empty, `fifo_level` is 0, and `thre_irq` equals `cfg_thre_ie`. With no frame in progress, `txd` is high unless break is enabled.
- R2: Data framing. A frame starts with a start bit of 0, followed by `5 + cfg_data_len` data bits, least significant bit first. The codes are 0 = 5 bits, 1 = 6, 2 = 7 and 3 = 8.
- R3: Parity. When `cfg_parity_en` is 1, a parity bit follows the data bits. With `cfg_parity_odd` = 0, the parity bit makes the count of ones across data and parity even. With `cfg_parity_odd` = 1, it makes that count odd.
- R4: Stop length. The stop period is high for 16 ticks when `cfg_stop_sel` = 0, for 24 ticks when it is 1, and for 32 ticks when it is 2 or 3.
- R5: Bit timing. A tick occurs once every `cfg_divisor` clocks, and a divisor of 0 acts as 1. Start, data and parity bits each last 16 ticks. A frame starts only on a tick.
- R6: Line break. While `cfg_break` = 1, `txd` is 0 and no byte leaves the queue. A frame already in progress continues internally, hidden by the forced low.
- R7: Queue. The queue holds 16 bytes. A write while `fifo_full` is high is dropped. `fifo_level`, `fifo_full` and `fifo_empty` show the number of bytes held.
- R8: Flow control. While `cfg_flow_en` = 1 and `cts` = 0, no new frame starts. A frame already in progress completes.
- R9: `thre_irq` is high exactly when `cfg_thre_ie` = 1 and the queue is empty.
- R10: Back-to-back frames. If a byte is waiting and starting is allowed, the next start bit begins on the tick that ends the previous stop period, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_divisor | input | 16 | Clocks per oversampling tick (0 acts as 1) |
| cfg_data_len | input | 2 | Data length code, 5 + value bits |
| cfg_parity_en | input | 1 | Parity bit appended when 1 |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_stop_sel | input | 2 | Stop length code: 0 = 1 bit, 1 = 1.5 bits, 2 or 3 = 2 bits |
| cfg_break | input | 1 | Forces the line low and blocks frame starts |
| cfg_flow_en | input | 1 | Makes frame starts depend on `cts` |
| cfg_thre_ie | input | 1 | Enables the empty interrupt |
| cts | input | 1 | Clear to send, active high |
| wr_valid | input | 1 | Pushes `wr_data` into the queue |
| wr_data | input | 8 | Byte to transmit |
| fifo_full | output | 1 | Queue holds 16 bytes |
| fifo_empty | output | 1 | Queue holds no bytes |
| fifo_level | output | 5 | Number of bytes held |
| txd | output | 1 | Serial output, idle high |
| thre_irq | output | 1 | Queue-empty interrupt |

## Verification
The assertions assume that the configuration inputs do not glitch within a cycle. They also assume that `wr_valid` and the control inputs change only between clock edges, so each pop and push is decided on the value sampled at the edge. The bench drives every input on the falling edge. It changes the divisor and format settings only while the queue is empty and no frame is in progress, and it toggles break and clear-to-send both while the line is idle and during a frame. In this way every sampled frame has one well-defined format, and the hold-off controls are still exercised both between and during frames.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int OVS = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  // Stop period length in oversampling ticks.
  function automatic logic [5:0] stop_ticks(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd16;
      2'd1:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  // Number of data bits per character.
  function automatic logic [3:0] data_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // Parity over the active data bits; odd = 1 inverts the even result.
  function automatic logic parity_of(input logic [7:0] d, input logic [1:0] len,
                                     input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(data_bits(len))) p = p ^ d[i];
    end
    return p;
  endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  assign limit = (divisor == '0) ? '0 : divisor - 1'b1;
  assign tick  = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_wr, do_rd;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       can_go,
  input  logic [7:0] head,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [1:0] cfg_stop,
  output logic       pop,
  output logic       line,
  output logic       busy
);
  tx_state_e  state;
  logic [5:0] cnt;
  logic [3:0] sent;
  logic [3:0] nbits_q;
  logic [7:0] shreg;
  logic       par_en_q, par_bit_q;
  logic [5:0] stop_q;
  logic       bit_end, stop_end;

  assign bit_end  = (cnt == 6'(OVS - 1));
  assign stop_end = (cnt == stop_q - 6'd1);
  assign pop      = tick && can_go &&
                    ((state == ST_IDLE) || (state == ST_STOP && stop_end));
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      sent      <= '0;
      nbits_q   <= 4'd8;
      shreg     <= '0;
      par_en_q  <= 1'b0;
      par_bit_q <= 1'b0;
      stop_q    <= 6'd16;
      line      <= 1'b1;
    end else if (pop) begin
      state     <= ST_START;
      cnt       <= '0;
      sent      <= '0;
      line      <= 1'b0;
      shreg     <= head;
      nbits_q   <= data_bits(cfg_len);
      par_en_q  <= cfg_par_en;
      par_bit_q <= parity_of(head, cfg_len, cfg_par_odd);
      stop_q    <= stop_ticks(cfg_stop);
    end else if (tick) begin
      case (state)
        ST_START: begin
          if (bit_end) begin
            state <= ST_DATA;
            cnt   <= '0;
            line  <= shreg[0];
            shreg <= shreg >> 1;
            sent  <= 4'd1;
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: begin
          if (bit_end) begin
            cnt <= '0;
            if (sent == nbits_q) begin
              state <= par_en_q ? ST_PAR : ST_STOP;
              line  <= par_en_q ? par_bit_q : 1'b1;
            end else begin
              line  <= shreg[0];
              shreg <= shreg >> 1;
              sent  <= sent + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        ST_PAR: begin
          if (bit_end) begin
            state <= ST_STOP;
            cnt   <= '0;
            line  <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        ST_STOP: begin
          if (stop_end) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: cnt <= '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_divisor,
  input  logic [1:0]       cfg_data_len,
  input  logic             cfg_parity_en,
  input  logic             cfg_parity_odd,
  input  logic [1:0]       cfg_stop_sel,
  input  logic             cfg_break,
  input  logic             cfg_flow_en,
  input  logic             cfg_thre_ie,
  input  logic             cts,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             fifo_full,
  output logic             fifo_empty,
  output logic [LW-1:0]    fifo_level,
  output logic             txd,
  output logic             thre_irq
);
  // Internal events exposed for the checker.
  logic       baud_tick;
  logic       pop_evt;
  logic       frame_busy;
  logic       start_ok;
  logic       line_bit;
  logic [7:0] head_byte;

  assign start_ok = !fifo_empty && !cfg_break && (!cfg_flow_en || cts);

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .divisor (cfg_divisor),
    .tick    (baud_tick)
  );

  uart_tx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_valid),
    .wr_data (wr_data),
    .rd_en   (pop_evt),
    .rd_data (head_byte),
    .level   (fifo_level),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  uart_tx_framer u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (baud_tick),
    .can_go      (start_ok),
    .head        (head_byte),
    .cfg_len     (cfg_data_len),
    .cfg_par_en  (cfg_parity_en),
    .cfg_par_odd (cfg_parity_odd),
    .cfg_stop    (cfg_stop_sel),
    .pop         (pop_evt),
    .line        (line_bit),
    .busy        (frame_busy)
  );

  assign txd      = line_bit && !cfg_break;
  assign thre_irq = cfg_thre_ie && fifo_empty;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk #(
  parameter int LW = 5,
  parameter int DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txd,
  input logic          cfg_break,
  input logic          cfg_flow_en,
  input logic          cts,
  input logic          wr_valid,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic [LW-1:0] fifo_level,
  input logic          thre_irq,
  input logic          baud_tick,
  input logic          pop_evt,
  input logic          frame_busy
);
  p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_busy && !cfg_break) |-> txd);

  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |=> !txd);

  p_start_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_evt |-> baud_tick);

  p_break_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_break |-> (!txd && !pop_evt));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && wr_valid && !pop_evt) |=> (fifo_full && $stable(fifo_level)));

  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level <= LW'(DEPTH)) && !(fifo_empty && pop_evt));

  p_cts_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flow_en && !cts) |-> !pop_evt);

  p_irq_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    thre_irq |-> (fifo_level == '0));
endmodule

bind uart_tx_core uart_tx_chk #(.LW(LW), .DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .txd         (txd),
  .cfg_break   (cfg_break),
  .cfg_flow_en (cfg_flow_en),
  .cts         (cts),
  .wr_valid    (wr_valid),
  .fifo_full   (fifo_full),
  .fifo_empty  (fifo_empty),
  .fifo_level  (fifo_level),
  .thre_irq    (thre_irq),
  .baud_tick   (baud_tick),
  .pop_evt     (pop_evt),
  .frame_busy  (frame_busy)
);

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div = 16'd1;
  logic [1:0]  len = 2'd3;
  logic        par_en = 1'b0, par_odd = 1'b0;
  logic [1:0]  stop = 2'd0;
  logic        brk = 1'b0, flow = 1'b0, ie = 1'b1, cts = 1'b1;
  logic        wr = 1'b0;
  logic [7:0]  wd = 8'h00;
  logic        full, empty, txd, irq;
  logic [4:0]  level;

  int    vectors = 0, miscompares = 0;
  bit    done = 1'b0;
  string cur_req = "R2 framing";

  always #2.5 clk = ~clk;

  uart_tx_core u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_divisor(div), .cfg_data_len(len),
    .cfg_parity_en(par_en), .cfg_parity_odd(par_odd), .cfg_stop_sel(stop),
    .cfg_break(brk), .cfg_flow_en(flow), .cfg_thre_ie(ie), .cts(cts),
    .wr_valid(wr), .wr_data(wd), .fifo_full(full), .fifo_empty(empty),
    .fifo_level(level), .txd(txd), .thre_irq(irq)
  );

  // Behavioural reference: a byte queue plus a list of (level, duration) segments.
  int m_q[$];
  int m_bits[$];
  int m_durs[$];
  int m_bcnt, m_rem;
  bit m_busy, m_line;

  task automatic m_start();
    int d, n, p;
    d = m_q.pop_front();
    n = 5 + int'(len);
    p = int'(par_odd);
    for (int i = 0; i < n; i++) begin
      m_bits.push_back((d >> i) & 1);
      m_durs.push_back(16);
      p = p ^ ((d >> i) & 1);
    end
    if (par_en) begin
      m_bits.push_back(p);
      m_durs.push_back(16);
    end
    m_bits.push_back(1);
    m_durs.push_back(stop == 2'd0 ? 16 : (stop == 2'd1 ? 24 : 32));
    m_line = 1'b0;
    m_rem  = 16;
    m_busy = 1'b1;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_bits.delete(); m_durs.delete();
      m_bcnt = 0; m_rem = 0; m_busy = 1'b0; m_line = 1'b1;
    end else begin
      int  de, sz;
      bit  tk, go;
      de = (div == 16'd0) ? 1 : int'(div);
      tk = (m_bcnt >= de - 1);
      sz = m_q.size();
      go = (sz > 0) && !brk && (!flow || cts);
      m_bcnt = tk ? 0 : m_bcnt + 1;
      if (tk) begin
        if (m_busy) begin
          m_rem--;
          if (m_rem == 0) begin
            if (m_bits.size() > 0) begin
              m_line = m_bits.pop_front()[0];
              m_rem  = m_durs.pop_front();
            end else begin
              m_busy = 1'b0;
              m_line = 1'b1;
            end
          end
        end
        if (!m_busy && go) m_start();
      end
      if (wr && sz < 16) m_q.push_back(int'(wd));
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Per-clock comparison, 1 ns after the active edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(cur_req, int'(txd), int'(m_line && !brk));
      chk("R7 level", int'(level), m_q.size());
      chk("R7 full", int'(full), int'(m_q.size() == 16));
      chk("R7 empty", int'(empty), int'(m_q.size() == 0));
      chk("R9 irq", int'(irq), int'(ie && m_q.size() == 0));
    end
  end

  task automatic push(int b);
    @(negedge clk);
    wr = 1'b1; wd = 8'(b);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (m_q.size() != 0 || m_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic fmt(int d, int l, bit pe, bit po, int s);
    div = 16'(d); len = 2'(l); par_en = pe; par_odd = po; stop = 2'(s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset txd", int'(txd), 1);
    chk("R1 reset level", int'(level), 0);
    chk("R1 reset irq", int'(irq), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle txd", int'(txd), 1);

    cur_req = "R2 R10 8N1 back-to-back";
    fmt(1, 3, 0, 0, 0);
    push(8'hA5); push(8'h3C); push(8'h01);
    drain();

    cur_req = "R3 R4 5E1.5";
    fmt(2, 0, 1, 0, 1);
    push(8'h13); push(8'h1F); push(8'h00);
    drain();

    cur_req = "R3 R4 7O2";
    fmt(3, 2, 1, 1, 2);
    push(8'h55); push(8'h7E);
    drain();

    cur_req = "R2 R4 6N2 code3";
    fmt(1, 1, 0, 0, 3);
    push(8'h2A); push(8'h15);
    drain();

    cur_req = "R5 divisor zero";
    fmt(0, 3, 1, 0, 0);
    push(8'hC3);
    drain();

    // R7 overflow with R8 hold-off
    cur_req = "R8 cts hold";
    fmt(1, 3, 0, 0, 0);
    flow = 1'b1; cts = 1'b0;
    for (int i = 0; i < 20; i++) push(i + 8'h40);
    chk("R7 level at full", int'(level), 16);
    chk("R7 full flag", int'(full), 1);
    repeat (400) @(negedge clk);
    chk("R8 no start while cts low", int'(level), 16);
    chk("R8 line idle", int'(txd), 1);
    cts = 1'b1;
    drain();

    // R8 mid-frame: current finishes, next held
    push(8'h81); push(8'h82);
    while (!m_busy) @(negedge clk);
    cts = 1'b0;
    while (m_busy) @(negedge clk);
    repeat (50) @(negedge clk);
    chk("R8 second held", int'(level), 1);
    cts = 1'b1; flow = 1'b0;
    drain();

    // R6 break while idle with data queued
    cur_req = "R6 break";
    brk = 1'b1;
    push(8'h11); push(8'h22); push(8'h33);
    repeat (300) @(negedge clk);
    chk("R6 txd low", int'(txd), 0);
    chk("R6 no pop", int'(level), 3);
    brk = 1'b0;
    drain();

    // R6 break mid-frame
    push(8'hF0);
    while (!m_busy) @(negedge clk);
    repeat (20) @(negedge clk);
    brk = 1'b1;
    repeat (30) @(negedge clk);
    chk("R6 forced low mid-frame", int'(txd), 0);
    brk = 1'b0;
    drain();

    // R9 interrupt disabled
    ie = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 irq masked", int'(irq), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule